// File: doc/BRIEF.md
# Shared-Unit Euler Step Datapath

This block advances a second-order differential equation by one explicit Euler step. A one-cycle start pulse captures five signed operands: position `x`, second state `y`, velocity `u`, step size `dx` and a bound `a`. The block returns `xl = x + dx`, `yl = y + u*dx`, `ul = u - 3*x*u*dx - 3*y*dx` and a flag `c` that is set when `xl` is below `a`. All values are 16-bit two's complement. Every product and sum wraps modulo 2^16.

The eleven arithmetic operations do not each get their own hardware. They run on two multipliers (M0, M1) and two add/subtract/compare units (A0, A1) over four fixed control steps:

| Step | M0 | M1 | A0 | A1 |
|------|----|----|----|----|
| 1 | 3·x | u·dx | x+dx | – |
| 2 | (3·x)·(u·dx) | 3·y | – | (x+dx) < a |
| 3 | (3·y)·dx | u·dx | u − 3xu·dx | – |
| 4 | – | – | step-3 result − 3y·dx | y + u·dx |

No unit runs two operations in the same step, and each operation starts only after the steps that produce its operands. Results pass between steps in intermediate registers.

The controller has six states:
- `ST_IDLE`: goes to `ST_STEP1` on start and captures the operands.
- `ST_STEP1` → `ST_STEP2` → `ST_STEP3` → `ST_STEP4`: one step per clock, with no condition on the transitions.
- `ST_STEP4` → `ST_FINISH`: the outputs are loaded on this edge and done is raised.
- `ST_FINISH` → `ST_IDLE`: done is lowered.

Start is looked at only in `ST_IDLE`.

Top module: `ode_step_engine`

## Requirements
- R1: `xl_o` equals `x + dx`, truncated to 16 bits.
- R2: `yl_o` equals `y + u*dx`, with the product truncated to 16 bits.
- R3: `ul_o` equals `u - (3*x)*(u*dx) - (3*y)*dx`, with every product and difference truncated to 16 bits.
- R4: `c_o` is 1 exactly when the truncated `xl` is less than `a`, both compared as signed values; otherwise it is 0.
- R5: `done_o` goes high for exactly one cycle. It rises on the 4th rising edge after the edge that samples `start_i` high in idle.
- R6: While a computation is in progress (from the capture edge through the cycle in which `done_o` is high), `start_i` and changes on the operand inputs are ignored. They do not change the result, and they do not produce an extra done pulse.
- R7: The outputs change only on the edge that raises `done_o`. They hold their values until the next completion.
- R8: After reset, `done_o` is 0, all outputs are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; operands are captured when idle |
| x_i | input | 16 | Position x, signed |
| y_i | input | 16 | Second state y, signed |
| u_i | input | 16 | Velocity u, signed |
| dx_i | input | 16 | Step size dx, signed |
| a_i | input | 16 | Compare bound a, signed |
| xl_o | output | 16 | Updated x |
| yl_o | output | 16 | Updated y |
| ul_o | output | 16 | Updated u |
| c_o | output | 1 | Flag: updated x is less than a |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Each of the four outputs is built from a different chain of intermediate registers. A wrong operand select or a wrong register load in any step therefore shows up in one specific output, and it shows up on the very done pulse of the same run. A controller that skips a step or re-enters one moves the done pulse off its fourth-edge position, or repeats it, within a few cycles. The bench sweeps small signed values of `x` and `dx`, then random operands with a mix of signs. While a run is in progress it also injects start pulses with unrelated operands, so a broken ignore rule corrupts the result that is checked.

// File: rtl/ode_step_pkg.sv
package ode_step_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP1,
        ST_STEP2,
        ST_STEP3,
        ST_STEP4,
        ST_FINISH
    } step_state_t;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_LT
    } alu_op_t;

    localparam int N_MUL = 2;
    localparam int N_ALU = 2;
endpackage

// File: rtl/ode_mul_unit.sv
module ode_mul_unit #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] p_o
);
    // The low WIDTH bits of a product are the same for signed and unsigned operands.
    always_comb begin
        p_o = a_i * b_i;
    end
endmodule

// File: rtl/ode_alu_unit.sv
module ode_alu_unit
    import ode_step_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alu_op_t          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] r_o
);
    always_comb begin
        r_o = '0;
        unique case (op_i)
            ALU_ADD: r_o = a_i + b_i;
            ALU_SUB: r_o = a_i - b_i;
            ALU_LT:  r_o = {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            default: r_o = '0;
        endcase
    end
endmodule

// File: rtl/ode_step_ctrl.sv
module ode_step_ctrl
    import ode_step_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output step_state_t state_o,
    output logic        done_o
);
    step_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_STEP1;
            ST_STEP1:  state_d = ST_STEP2;
            ST_STEP2:  state_d = ST_STEP3;
            ST_STEP3:  state_d = ST_STEP4;
            ST_STEP4:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= (state_q == ST_STEP4);
    end

    assign state_o = state_q;

    // R5: done lasts exactly one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R5: done follows the fourth step
    a_r5_done_after_step4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP4) |=> done_o);
    // R6: a busy controller never starts a new schedule
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_STEP1));
endmodule

// File: rtl/ode_step_engine.sv
module ode_step_engine
    import ode_step_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic [WIDTH-1:0] u_i,
    input  logic [WIDTH-1:0] dx_i,
    input  logic [WIDTH-1:0] a_i,
    output logic [WIDTH-1:0] xl_o,
    output logic [WIDTH-1:0] yl_o,
    output logic [WIDTH-1:0] ul_o,
    output logic             c_o,
    output logic             done_o
);
    localparam logic [WIDTH-1:0] K3 = WIDTH'(3);

    step_state_t state;

    ode_step_ctrl ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .state_o (state),
        .done_o  (done_o)
    );

    // captured operands
    logic [WIDTH-1:0] x_q, y_q, u_q, dx_q, a_q;
    // intermediate values, named by the operation that produces them
    logic [WIDTH-1:0] v1_q, v2_q, v3_q, v4_q, v6_q, v7_q, v8_q, v10_q;
    logic             v11_q;

    logic [WIDTH-1:0] mul_a [N_MUL];
    logic [WIDTH-1:0] mul_b [N_MUL];
    logic [WIDTH-1:0] mul_p [N_MUL];
    alu_op_t          alu_op [N_ALU];
    logic [WIDTH-1:0] alu_a  [N_ALU];
    logic [WIDTH-1:0] alu_b  [N_ALU];
    logic [WIDTH-1:0] alu_r  [N_ALU];

    for (genvar m = 0; m < N_MUL; m++) begin : g_mul
        ode_mul_unit #(.WIDTH(WIDTH)) mul_i (
            .a_i (mul_a[m]),
            .b_i (mul_b[m]),
            .p_o (mul_p[m])
        );
    end

    for (genvar k = 0; k < N_ALU; k++) begin : g_alu
        ode_alu_unit #(.WIDTH(WIDTH)) alu_i (
            .op_i (alu_op[k]),
            .a_i  (alu_a[k]),
            .b_i  (alu_b[k]),
            .r_o  (alu_r[k])
        );
    end

    // operand steering: fixed binding of the operations to the shared units
    always_comb begin
        for (int m = 0; m < N_MUL; m++) begin
            mul_a[m] = '0;
            mul_b[m] = '0;
        end
        for (int k = 0; k < N_ALU; k++) begin
            alu_op[k] = ALU_ADD;
            alu_a[k]  = '0;
            alu_b[k]  = '0;
        end
        unique case (state)
            ST_STEP1: begin
                mul_a[0] = K3;    mul_b[0] = x_q;    // v1
                mul_a[1] = u_q;   mul_b[1] = dx_q;   // v2
                alu_op[0] = ALU_ADD; alu_a[0] = x_q; alu_b[0] = dx_q; // v10
            end
            ST_STEP2: begin
                mul_a[0] = v1_q;  mul_b[0] = v2_q;   // v3
                mul_a[1] = K3;    mul_b[1] = y_q;    // v6
                alu_op[1] = ALU_LT; alu_a[1] = v10_q; alu_b[1] = a_q; // v11
            end
            ST_STEP3: begin
                mul_a[0] = v6_q;  mul_b[0] = dx_q;   // v7
                mul_a[1] = u_q;   mul_b[1] = dx_q;   // v8
                alu_op[0] = ALU_SUB; alu_a[0] = u_q; alu_b[0] = v3_q; // v4
            end
            ST_STEP4: begin
                alu_op[0] = ALU_SUB; alu_a[0] = v4_q; alu_b[0] = v7_q; // v5
                alu_op[1] = ALU_ADD; alu_a[1] = y_q;  alu_b[1] = v8_q; // v9
            end
            ST_IDLE, ST_FINISH: begin
            end
            default: begin
            end
        endcase
    end

    // operand capture, accepted only in idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0; y_q <= '0; u_q <= '0; dx_q <= '0; a_q <= '0;
        end else if (state == ST_IDLE && start_i) begin
            x_q <= x_i; y_q <= y_i; u_q <= u_i; dx_q <= dx_i; a_q <= a_i;
        end
    end

    // intermediate registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q <= '0; v2_q <= '0; v3_q <= '0; v4_q <= '0;
            v6_q <= '0; v7_q <= '0; v8_q <= '0; v10_q <= '0; v11_q <= 1'b0;
        end else begin
            unique case (state)
                ST_STEP1: begin
                    v1_q  <= mul_p[0];
                    v2_q  <= mul_p[1];
                    v10_q <= alu_r[0];
                end
                ST_STEP2: begin
                    v3_q  <= mul_p[0];
                    v6_q  <= mul_p[1];
                    v11_q <= alu_r[1][0];
                end
                ST_STEP3: begin
                    v7_q <= mul_p[0];
                    v8_q <= mul_p[1];
                    v4_q <= alu_r[0];
                end
                ST_IDLE, ST_STEP4, ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // result registers, loaded as the fourth step completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xl_o <= '0; yl_o <= '0; ul_o <= '0; c_o <= 1'b0;
        end else if (state == ST_STEP4) begin
            xl_o <= v10_q;
            c_o  <= v11_q;
            ul_o <= alu_r[0];
            yl_o <= alu_r[1];
        end
    end

    // R6: captured operands hold while busy
    a_r6_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable({x_q, y_q, u_q, dx_q, a_q}));
    // R7: outputs move only at completion
    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STEP4) |=> $stable({xl_o, yl_o, ul_o, c_o}));
    // R1: delivered xl matches the captured operands
    a_r1_xl_sum: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (xl_o == WIDTH'(x_q + dx_q)));
    // R4: flag agrees with the delivered xl and the captured bound
    a_r4_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (c_o == ($signed(xl_o) < $signed(a_q))));
endmodule

// File: tb/ode_step_engine_tb.sv
`timescale 1ns/1ps
module ode_step_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] x_i = '0, y_i = '0, u_i = '0, dx_i = '0, a_i = '0;
    logic [15:0] xl_o, yl_o, ul_o;
    logic        c_o, done_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    ode_step_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .x_i(x_i), .y_i(y_i), .u_i(u_i), .dx_i(dx_i), .a_i(a_i),
        .xl_o(xl_o), .yl_o(yl_o), .ul_o(ul_o), .c_o(c_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic run(input logic [15:0] x, y, u, dx, a, input bit poke);
        logic [15:0] exl, eyl, eul;
        logic        ec;
        exl = x + dx;
        eyl = y + u * dx;
        eul = u - (16'd3 * x) * (u * dx) - (16'd3 * y) * dx;
        ec  = $signed(exl) < $signed(a);
        @(negedge clk);
        x_i = x; y_i = y; u_i = u; dx_i = dx; a_i = a; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            start_i = 1'b1;
            x_i = ~x; y_i = y ^ 16'h5a5a; u_i = u + 16'd7; dx_i = ~dx; a_i = ~a;
        end
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            chk("R5 done early", {15'd0, done_o}, 16'd0);
        end
        @(negedge clk);
        start_i = 1'b0;
        chk("R5 done", {15'd0, done_o}, 16'd1);
        chk("R1 xl", xl_o, exl);
        chk("R2 yl", yl_o, eyl);
        chk("R3 ul", ul_o, eul);
        chk("R4 c", {15'd0, c_o}, {15'd0, ec});
        @(negedge clk);
        chk("R5 done width", {15'd0, done_o}, 16'd0);
        chk("R7 xl hold", xl_o, exl);
        chk("R7 ul hold", ul_o, eul);
        if (poke) begin
            @(negedge clk);
            chk("R6 no extra done", {15'd0, done_o}, 16'd0);
            chk("R6 yl kept", yl_o, eyl);
            chk("R6 c kept", {15'd0, c_o}, {15'd0, ec});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 done", {15'd0, done_o}, 16'd0);
        chk("R8 xl", xl_o, 16'd0);
        chk("R8 yl", yl_o, 16'd0);
        chk("R8 ul", ul_o, 16'd0);
        chk("R8 c", {15'd0, c_o}, 16'd0);
        rst_n = 1'b1;
        // directed corners: zeros, wrap of xl, negative operands
        run(16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0);
        run(16'h7fff, 16'd5, 16'd2, 16'd1, 16'd0, 1'b0);
        run(16'hfffd, 16'hfff0, 16'h0009, 16'hfffe, 16'hffff, 1'b0);
        run(16'h8000, 16'h7fff, 16'h8000, 16'hffff, 16'h7fff, 1'b1);
        // R4: xl exactly equal to a gives 0
        run(16'd10, 16'd1, 16'd1, 16'd3, 16'd13, 1'b0);
        // near-exhaustive sweep of small signed x and dx
        for (int xs = -4; xs <= 3; xs++) begin
            for (int ds = -4; ds <= 3; ds++) begin
                run(16'(xs), 16'(xs - ds), 16'(ds * 3 + 1), 16'(ds), 16'(xs + 1), 1'(ds[0]));
            end
        end
        // random operands with both signs; start poked while busy on odd runs
        for (int n = 0; n < 200; n++) begin
            run(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                16'($urandom), 1'(n % 2));
        end
        summary();
    end
endmodule